// File: doc/BRIEF.md
# Inter-Processor Mailbox Unit

This block passes 32-bit messages between a local compute core and a host processor. Messages from the host to the core go through a four-entry first-in first-out inbound mailbox. Messages from the core to the host go through one of two single-entry outbound mailboxes: a plain one and an interrupt-type one. Interrupt delivery itself is not part of this block.

The two sides treat full and empty mailboxes differently. The core side behaves like a blocking channel. A read request on an empty inbound mailbox, or a write request on a full outbound mailbox, raises a stall signal and is held until the other side acts. The core can also look at live counts before it issues a request. The host side is a non-blocking register port. A read of an empty outbound mailbox returns zero. A write to a full inbound mailbox replaces the newest entry. A status word reports the fill levels so the host can avoid both cases.

Host reads and core reads both deliver their data one cycle after the request is accepted, from registers.

Top module: `mbox_unit`

## Requirements
- R1: The core reads inbound messages in the order the host wrote them. A core read accepted at one clock edge raises `core_rd_valid` for exactly one cycle after that edge, with the message on `core_rd_data`.
- R2: While `core_rd_req` is high and the inbound mailbox is empty, `core_rd_stall` is high and no read is accepted. After a host write, the stall falls in the cycle after that write's edge.
- R3: While `core_wr_req` is high and the selected outbound mailbox is full, `core_wr_stall` is high and the mailbox contents do not change. `core_wr_sel` picks the mailbox: 0 selects the plain mailbox and 1 selects the interrupt-type mailbox.
- R4: The inbound mailbox holds 4 messages and each outbound mailbox holds 1 message. No count ever exceeds its capacity.
- R5: `core_in_avail` always equals the number of inbound messages. `core_out_free` and `core_irq_free` always equal the free slots of the plain and interrupt-type outbound mailboxes.
- R6: A host read of an empty outbound mailbox returns 0 and changes no state.
- R7: A host write to the full inbound mailbox replaces the most recently written entry. The count stays 4 and the three older entries keep their values and order.
- R8: The status word holds the following fields, with bits 31:24 zero:

  | Bits | Content |
  |------|---------|
  | 7:0 | Plain outbound message count |
  | 15:8 | Free inbound slots |
  | 23:16 | Interrupt-type outbound message count |

- R9: A host read of a non-empty outbound mailbox returns the message and empties that mailbox. A core write stalled on that mailbox sees its stall fall in the next cycle and is accepted at the following edge.
- R10: Host register addresses are as follows. Host writes to addresses 1 to 3 are ignored, and host reads of address 0 return 0.

  | Address | Register |
  |---------|----------|
  | 0 | Inbound message write |
  | 1 | Plain outbound read |
  | 2 | Interrupt-type outbound read |
  | 3 | Status word |

- R11: After reset all mailboxes are empty and the status word reads 0x00000400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rd_req | input | 1 | Core requests an inbound message |
| core_rd_stall | output | 1 | Core read held: inbound mailbox empty |
| core_rd_valid | output | 1 | Core read data valid (one cycle) |
| core_rd_data | output | 32 | Inbound message delivered to the core |
| core_in_avail | output | 8 | Inbound messages available to the core |
| core_wr_req | input | 1 | Core requests an outbound write |
| core_wr_sel | input | 1 | Outbound mailbox select: 0 plain, 1 interrupt-type |
| core_wr_data | input | 32 | Outbound message from the core |
| core_wr_stall | output | 1 | Core write held: selected mailbox full |
| core_out_free | output | 8 | Free slots in the plain outbound mailbox |
| core_irq_free | output | 8 | Free slots in the interrupt-type outbound mailbox |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after the read |

## Verification
The assertions check several rules on every cycle:
- no count exceeds its capacity;
- a write to the full inbound mailbox leaves it full;
- a host read of an empty mailbox yields zero;
- a stalled core request delivers nothing;
- a host pop of a mailbox with a stalled writer clears that mailbox's full state on the next cycle;
- status reads keep the top byte zero.

Other behaviour can only be shown by the bench's scenarios, which compare against a queue model:
- the order of messages through the inbound mailbox;
- which entry an overwrite replaces;
- the cycle on which a stalled read or write is released;
- the exact status field positions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [1:0] {
    HA_INBOX      = 2'd0,
    HA_OUTBOX     = 2'd1,
    HA_OUTBOX_IRQ = 2'd2,
    HA_STATUS     = 2'd3
  } host_addr_e;

  function automatic logic [31:0] pack_status(
    input logic [FIELD_W-1:0] out_cnt,
    input logic [FIELD_W-1:0] in_free,
    input logic [FIELD_W-1:0] irq_cnt
  );
    return {8'd0, irq_cnt, in_free, out_cnt};
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  parameter bit OVERWRITE = 1'b0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     pop_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, newest, wr_addr;
  logic             do_pop, do_push, do_ovw, we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign do_ovw  = OVERWRITE && push && full && !do_pop;
  assign newest  = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
  assign wr_addr = do_ovw ? newest : wr_ptr;
  assign we      = do_push || do_ovw;

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      pop_data <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) begin
        rd_ptr   <= ptr_inc(rd_ptr);
        pop_data <= mem[rd_ptr];
      end else if (pop) begin
        pop_data <= '0;
      end
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_overwrite_stays_full_R7: assert property (@(posedge clk) disable iff (rst)
    (OVERWRITE && push && full && !pop) |=> full);

  assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pop_data == '0));

endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int W = 32,
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [1:0]         host_addr,
  input  logic [W-1:0]       host_wdata,
  input  logic [31:0]        status_in,
  input  logic [W-1:0]       out_data [NUM_OUT],
  output logic               in_push,
  output logic [W-1:0]       in_data,
  output logic [NUM_OUT-1:0] out_pop,
  output logic [W-1:0]       host_rdata
);

  host_addr_e  sel_q;
  logic        rd_q;
  logic [31:0] status_q;

  assign in_push = host_wr_en && (host_addr_e'(host_addr) == HA_INBOX);
  assign in_data = host_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_pop
      assign out_pop[g] = host_rd_en && (host_addr == 2'(g + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= HA_INBOX;
      rd_q     <= 1'b0;
      status_q <= '0;
    end else begin
      rd_q <= host_rd_en;
      if (host_rd_en) begin
        sel_q    <= host_addr_e'(host_addr);
        status_q <= status_in;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (rd_q) begin
      case (sel_q)
        HA_OUTBOX:     host_rdata = out_data[0];
        HA_OUTBOX_IRQ: host_rdata = out_data[1];
        HA_STATUS:     host_rdata = W'(status_q);
        default:       host_rdata = '0;
      endcase
    end
  end

  assert_status_top_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && host_addr == 2'd3) |=> (host_rdata[31:24] == 8'd0));

  assert_inbox_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && host_addr == 2'd0) |=> (host_rdata == '0));

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int W = 32,
  parameter int IN_DEPTH = 4,
  parameter int OUT_DEPTH = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               core_rd_req,
  output logic               core_rd_stall,
  output logic               core_rd_valid,
  output logic [W-1:0]       core_rd_data,
  output logic [FIELD_W-1:0] core_in_avail,
  input  logic               core_wr_req,
  input  logic               core_wr_sel,
  input  logic [W-1:0]       core_wr_data,
  output logic               core_wr_stall,
  output logic [FIELD_W-1:0] core_out_free,
  output logic [FIELD_W-1:0] core_irq_free,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [1:0]         host_addr,
  input  logic [W-1:0]       host_wdata,
  output logic [W-1:0]       host_rdata
);

  localparam int NUM_OUT = 2;
  localparam int IN_CW   = $clog2(IN_DEPTH + 1);
  localparam int OUT_CW  = $clog2(OUT_DEPTH + 1);

  logic             in_push, in_empty, in_full, in_pop;
  logic [W-1:0]     in_data;
  logic [IN_CW-1:0] in_count;

  logic [NUM_OUT-1:0] out_pop, out_push, out_full, out_empty;
  logic [W-1:0]       out_data [NUM_OUT];
  logic [OUT_CW-1:0]  out_count [NUM_OUT];
  logic [31:0]        status_w;

  // inbound: host writes, core reads; full writes replace the newest entry
  mbox_fifo #(.W(W), .DEPTH(IN_DEPTH), .OVERWRITE(1'b1)) u_inbox (
    .clk(clk), .rst(rst),
    .push(in_push), .push_data(in_data),
    .pop(in_pop), .pop_data(core_rd_data),
    .count(in_count), .full(in_full), .empty(in_empty)
  );

  assign core_rd_stall = core_rd_req && in_empty;
  assign in_pop        = core_rd_req && !in_empty;

  always_ff @(posedge clk) begin
    if (rst) core_rd_valid <= 1'b0;
    else     core_rd_valid <= in_pop;
  end

  assign core_wr_stall = core_wr_req && out_full[core_wr_sel];

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_out
      assign out_push[g] = core_wr_req && (core_wr_sel == 1'(g)) && !out_full[g];

      mbox_fifo #(.W(W), .DEPTH(OUT_DEPTH), .OVERWRITE(1'b0)) u_outbox (
        .clk(clk), .rst(rst),
        .push(out_push[g]), .push_data(core_wr_data),
        .pop(out_pop[g]), .pop_data(out_data[g]),
        .count(out_count[g]), .full(out_full[g]), .empty(out_empty[g])
      );

      assert_stall_holds_full_R3: assert property (@(posedge clk) disable iff (rst)
        (core_wr_req && core_wr_sel == 1'(g) && out_full[g] && !out_pop[g]) |=> out_full[g]);

      assert_pop_releases_R9: assert property (@(posedge clk) disable iff (rst)
        (core_wr_req && core_wr_sel == 1'(g) && out_full[g] && out_pop[g]) |=> !out_full[g]);
    end
  endgenerate

  assign core_in_avail = FIELD_W'(in_count);
  assign core_out_free = FIELD_W'(OUT_DEPTH) - FIELD_W'(out_count[0]);
  assign core_irq_free = FIELD_W'(OUT_DEPTH) - FIELD_W'(out_count[1]);

  assign status_w = pack_status(FIELD_W'(out_count[0]),
                                FIELD_W'(IN_DEPTH) - FIELD_W'(in_count),
                                FIELD_W'(out_count[1]));

  mbox_host_if #(.W(W), .NUM_OUT(NUM_OUT)) u_host (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .status_in(status_w), .out_data(out_data),
    .in_push(in_push), .in_data(in_data),
    .out_pop(out_pop), .host_rdata(host_rdata)
  );

  assert_rd_stall_no_data_R2: assert property (@(posedge clk) disable iff (rst)
    core_rd_stall |=> !core_rd_valid);

  assert_valid_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (core_rd_req && !core_rd_stall) |=> core_rd_valid);

endmodule

// File: tb/mbox_unit_tb_top.sv
module mbox_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_rd_req = 0, core_wr_req = 0, core_wr_sel = 0;
  logic [31:0] core_wr_data = 0;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [1:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic        core_rd_stall, core_rd_valid, core_wr_stall;
  logic [31:0] core_rd_data, host_rdata;
  logic [7:0]  core_in_avail, core_out_free, core_irq_free;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] in_q[$];
  logic [31:0] oq0[$];
  logic [31:0] oq1[$];

  always #10 clk = ~clk;

  mbox_unit dut_i (
    .clk(clk), .rst(rst),
    .core_rd_req(core_rd_req), .core_rd_stall(core_rd_stall),
    .core_rd_valid(core_rd_valid), .core_rd_data(core_rd_data),
    .core_in_avail(core_in_avail),
    .core_wr_req(core_wr_req), .core_wr_sel(core_wr_sel),
    .core_wr_data(core_wr_data), .core_wr_stall(core_wr_stall),
    .core_out_free(core_out_free), .core_irq_free(core_irq_free),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {8'd0, 8'(oq1.size()), 8'(4 - in_q.size()), 8'(oq0.size())};
  endfunction

  task automatic chk_counts();
    chk("R5 in_avail", 32'(core_in_avail), 32'(in_q.size()));
    chk("R5 out_free", 32'(core_out_free), 32'(1 - oq0.size()));
    chk("R5 irq_free", 32'(core_irq_free), 32'(1 - oq1.size()));
  endtask

  // inputs change at negedge; results are sampled one negedge later
  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
    if (a == 2'd0) begin
      if (in_q.size() < 4) in_q.push_back(d);
      else in_q[3] = d;
    end
  endtask

  task automatic host_read(input logic [1:0] a, input string req);
    logic [31:0] exp;
    case (a)
      2'd1: exp = (oq0.size() != 0) ? oq0.pop_front() : 32'd0;
      2'd2: exp = (oq1.size() != 0) ? oq1.pop_front() : 32'd0;
      2'd3: exp = exp_status();
      default: exp = 32'd0;
    endcase
    host_rd_en = 1; host_addr = a;
    @(negedge clk);
    host_rd_en = 0;
    chk(req, host_rdata, exp);
  endtask

  task automatic core_read(input string req);
    logic [31:0] exp;
    exp = in_q.pop_front();
    core_rd_req = 1;
    #1 chk("R2 no stall when data", 32'(core_rd_stall), 0);
    @(negedge clk);
    core_rd_req = 0;
    chk("R1 valid", 32'(core_rd_valid), 1);
    chk(req, core_rd_data, exp);
  endtask

  task automatic core_write(input logic sel, input logic [31:0] d);
    core_wr_req = 1; core_wr_sel = sel; core_wr_data = d;
    #1 chk("R3 no stall when room", 32'(core_wr_stall), 0);
    @(negedge clk);
    core_wr_req = 0;
    if (sel) oq1.push_back(d); else oq0.push_back(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    chk_counts();
    host_read(2'd3, "R11 reset status");
    chk("R11 status value", host_rdata, 32'h0000_0400);
    host_read(2'd1, "R6 empty outbox reads zero");
    host_read(2'd2, "R6 empty irq outbox reads zero");
    chk_counts();

    // R2 blocking read, release after host write
    core_rd_req = 1;
    @(negedge clk);
    chk("R2 stall on empty", 32'(core_rd_stall), 1);
    chk("R2 no valid while stalled", 32'(core_rd_valid), 0);
    host_wr_en = 1; host_addr = 2'd0; host_wdata = 32'hCAFE_0001;
    @(negedge clk);
    host_wr_en = 0;
    chk("R2 stall released", 32'(core_rd_stall), 0);
    @(negedge clk);
    core_rd_req = 0;
    chk("R2 valid after release", 32'(core_rd_valid), 1);
    chk("R2 data after release", core_rd_data, 32'hCAFE_0001);
    @(negedge clk);
    chk("R1 valid one cycle", 32'(core_rd_valid), 0);

    // R10 writes to non-inbox addresses ignored, inbox read is zero
    host_write(2'd1, 32'h1111_1111);
    host_write(2'd3, 32'h3333_3333);
    host_read(2'd0, "R10 inbox address reads zero");
    host_read(2'd3, "R10 ignored writes status");
    chk_counts();

    // R1 order and R7 overwrite of newest
    host_write(2'd0, 32'hA0);
    host_write(2'd0, 32'hA1);
    host_write(2'd0, 32'hA2);
    host_write(2'd0, 32'hA3);
    host_write(2'd0, 32'hA4);
    host_write(2'd0, 32'hA5);
    chk("R7 count stays 4", 32'(core_in_avail), 4);
    host_read(2'd3, "R8 status full inbox");
    core_read("R7 oldest kept");
    core_read("R7 second kept");
    core_read("R7 third kept");
    core_read("R7 newest replaced");
    chk_counts();

    // R3 write stall and R9 release after host pop
    core_write(1'b0, 32'hB000_0001);
    core_write(1'b1, 32'hB000_0002);
    host_read(2'd3, "R8 status both outboxes");
    core_wr_req = 1; core_wr_sel = 0; core_wr_data = 32'hB000_0003;
    @(negedge clk);
    chk("R3 stall on full", 32'(core_wr_stall), 1);
    chk("R3 count held", 32'(core_out_free), 0);
    host_rd_en = 1; host_addr = 2'd1;
    @(negedge clk);
    host_rd_en = 0;
    chk("R9 pop returns message", host_rdata, 32'hB000_0001);
    chk("R9 stall falls next cycle", 32'(core_wr_stall), 0);
    @(negedge clk);
    core_wr_req = 0;
    chk("R9 write accepted", 32'(core_out_free), 0);
    void'(oq0.pop_front());
    oq0.push_back(32'hB000_0003);
    host_read(2'd1, "R9 released write data");
    host_read(2'd2, "R9 irq outbox data");
    host_read(2'd2, "R6 drained irq reads zero");
    chk_counts();

    // constrained random mix against the queue model
    for (int i = 0; i < 600; i++) begin
      int op;
      logic sel;
      op = $urandom_range(0, 5);
      case (op)
        0: host_write(2'd0, $urandom);
        1: host_read(2'd1, "R9 random plain read");
        2: host_read(2'd2, "R9 random irq read");
        3: host_read(2'd3, "R8 random status");
        4: begin
          if (in_q.size() != 0) core_read("R1 random order");
          else begin
            core_rd_req = 1;
            #1 chk("R2 random stall", 32'(core_rd_stall), 1);
            @(negedge clk);
            core_rd_req = 0;
            chk("R2 random no valid", 32'(core_rd_valid), 0);
          end
        end
        default: begin
          sel = 1'($urandom_range(0, 1));
          if ((sel ? oq1.size() : oq0.size()) == 0) core_write(sel, $urandom);
          else begin
            core_wr_req = 1; core_wr_sel = sel; core_wr_data = $urandom;
            #1 chk("R3 random stall", 32'(core_wr_stall), 1);
            @(negedge clk);
            core_wr_req = 0;
          end
        end
      endcase
      chk_counts();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule